// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. Software sets it up through three registers on a simple synchronous register port. The first is a timer entry that holds an 8-bit vector, a mask bit and a mode bit. The second is a reload value, which also starts the count. The third is a divider setting. The block divides its clock by a power of two, counts the live value down once per divided tick, and makes that value readable.

When the count expires, the block drives a one-cycle interrupt request that carries the entry's vector, unless the entry is masked. In one-shot mode the count stops at zero after a single request. In periodic mode the count reloads and fires again on every wrap.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The reload value, the live count and the divider setting read 0, and no request is raised.
- R2: A divider write keeps only bits 3, 1 and 0 (mask 0xB). The register reads back that masked value.
- R3: The divider code is {bit3, bit1, bit0}. The prescale shift is (code + 1) mod 8, and the live count steps once every 2^shift clocks, so code 7 (setting 0xB) steps on every clock.
- R4: A write to the reload register or the divider register restarts the prescaler. The first step then comes exactly 2^shift clocks after that write.
- R5: A write to the reload register loads the live count with the written value at once and arms the timer.
- R6: In one-shot mode (entry bit 17 = 0) the count falls to 0 and stays there. Exactly one request is raised, on the first divided tick that finds the count at 0, which is reload+1 ticks after the write.
- R7: In periodic mode (entry bit 17 = 1) a divided tick that finds the count at 0 reloads the reload value and raises a request. The period is therefore reload+1 ticks.
- R8: In periodic mode with a reload value of 0, no request is ever raised and the count stays at 0.
- R9: While entry bit 16 is set, no request is raised, but the count keeps running.
- R10: A request is `irq_pulse` high for one cycle, the cycle after the expiring tick. During that cycle `irq_vector` equals entry bits 7:0; at all other times it is 0.
- R11: An entry write keeps only bits 17, 16 and 7:0. Reading any register, including the live count, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 entry, 1 reload, 2 live count (read-only), 3 divider |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request, 0 otherwise |

## Verification
A prescaler phase that slips shows up on the live-count read within one divided period, because the count steps one cycle early or late. A bad armed flag or a bad reload shows up at the first expiry: there is a missing, extra or mistimed pulse, or the count reads a wrong value on the cycle after the wrap. A reference model compares the count read and both request outputs on every clock, so each such fault is seen on the first cycle where it differs.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam int SHIFT_W = 3;
  localparam int VEC_W   = 8;
  localparam int ENTRY_PERIODIC_BIT = 17;
  localparam int ENTRY_MASK_BIT     = 16;
  localparam logic [3:0] DIV_KEEP  = 4'hB;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_NOW   = 2'd2,
    SEL_DIV   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vec;
  } entry_t;

  // shift = ({b3,b1,b0} + 1) mod 8
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    return code + SHIFT_W'(1);
  endfunction

  // all-ones limit of the prescaler phase for a given shift
  function automatic logic [(1<<SHIFT_W)-2:0] phase_limit(input logic [SHIFT_W-1:0] sh);
    return ~({((1<<SHIFT_W)-1){1'b1}} << sh);
  endfunction
endpackage

// File: rtl/timer_regs.sv
`timescale 1ns/1ps
module timer_regs
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] live_count,
  output entry_t           entry,
  output logic [CNT_W-1:0] reload_val,
  output logic [3:0]       div_cfg,
  output logic             reload_wr,
  output logic             div_wr,
  output logic [31:0]      rdata
);
  logic entry_wr;

  assign entry_wr  = wr_en && (reg_sel_e'(addr) == SEL_ENTRY);
  assign reload_wr = wr_en && (reg_sel_e'(addr) == SEL_LOAD);
  assign div_wr    = wr_en && (reg_sel_e'(addr) == SEL_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry      <= '{periodic: 1'b0, masked: 1'b1, vec: '0};
      reload_val <= '0;
      div_cfg    <= '0;
    end else begin
      if (entry_wr) begin
        entry.periodic <= wdata[ENTRY_PERIODIC_BIT];
        entry.masked   <= wdata[ENTRY_MASK_BIT];
        entry.vec      <= wdata[VEC_W-1:0];
      end
      if (reload_wr) reload_val <= wdata[CNT_W-1:0];
      if (div_wr)    div_cfg    <= wdata[3:0] & DIV_KEEP;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(addr))
      SEL_ENTRY: begin
        rdata[ENTRY_PERIODIC_BIT] = entry.periodic;
        rdata[ENTRY_MASK_BIT]     = entry.masked;
        rdata[VEC_W-1:0]          = entry.vec;
      end
      SEL_LOAD: rdata[CNT_W-1:0] = reload_val;
      SEL_NOW:  rdata[CNT_W-1:0] = live_count;
      SEL_DIV:  rdata[3:0]       = div_cfg;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/timer_prescaler.sv
`timescale 1ns/1ps
module timer_prescaler
  import timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PH_W = (1 << SHIFT_W) - 1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] limit;

  assign limit = phase_limit(shift);
  assign tick  = !restart && (phase == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= '0;
    else if (restart || tick)  phase <= '0;
    else                       phase <= phase + PH_W'(1);
  end
endmodule

// File: rtl/timer_core.sv
`timescale 1ns/1ps
module timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic armed;
  logic at_zero;

  assign at_zero = (count == '0);
  assign expire  = tick && armed && at_zero && (!periodic || (reload_val != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (load) begin
      count <= load_val;
      armed <= 1'b1;
    end else if (tick) begin
      if (!at_zero)      count <= count - CNT_W'(1);
      else if (armed) begin
        if (periodic)    count <= reload_val;
        else             armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_countdown_timer.sv
`timescale 1ns/1ps
module irq_countdown_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector
);
  entry_t             entry;
  logic [CNT_W-1:0]   reload_val;
  logic [CNT_W-1:0]   live_count;
  logic [3:0]         div_cfg;
  logic               reload_wr;
  logic               div_wr;
  logic               tick;
  logic               expire;
  logic               entry_masked;
  logic               entry_periodic;
  logic [VEC_W-1:0]   entry_vec;

  assign entry_masked   = entry.masked;
  assign entry_periodic = entry.periodic;
  assign entry_vec      = entry.vec;

  timer_regs #(.CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .live_count(live_count), .entry(entry), .reload_val(reload_val),
    .div_cfg(div_cfg), .reload_wr(reload_wr), .div_wr(div_wr), .rdata(reg_rdata)
  );

  timer_prescaler i_pre (
    .clk(clk), .rst_n(rst_n), .restart(reload_wr || div_wr),
    .shift(div_shift(div_cfg)), .tick(tick)
  );

  timer_core #(.CNT_W(CNT_W)) i_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(reload_wr),
    .load_val(reg_wdata[CNT_W-1:0]), .reload_val(reload_val),
    .periodic(entry_periodic), .count(live_count), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse  <= expire && !entry_masked;
      irq_vector <= (expire && !entry_masked) ? entry_vec : '0;
    end
  end
endmodule

// File: rtl/timer_checker.sv
`timescale 1ns/1ps
module timer_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             expire,
  input logic             reload_wr,
  input logic [CNT_W-1:0] live_count,
  input logic [CNT_W-1:0] reload_val,
  input logic             entry_masked,
  input logic             entry_periodic,
  input logic [7:0]       entry_vec,
  input logic             irq_pulse,
  input logic [7:0]       irq_vector
);
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && entry_masked) |=> !irq_pulse);

  // R10
  vector_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !entry_masked) |=> (irq_pulse && irq_vector == $past(entry_vec)));

  // R6
  expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (tick && live_count == '0));

  // R8
  periodic_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && entry_periodic) |-> (reload_val != '0));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload_wr) |=> $stable(live_count));

  // R10
  vector_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> (irq_vector == 8'd0));
endmodule

bind irq_countdown_timer timer_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire), .reload_wr(reload_wr),
  .live_count(live_count), .reload_val(reload_val), .entry_masked(entry_masked),
  .entry_periodic(entry_periodic), .entry_vec(entry_vec),
  .irq_pulse(irq_pulse), .irq_vector(irq_vector)
);

// File: tb/test_irq_countdown_timer.sv
`timescale 1ns/1ps
module test_irq_countdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int    checks = 0;
  int    fails  = 0;
  int    pulses = 0;
  string cur_req = "R1";

  // behavioural reference state
  int unsigned m_entry = 32'h0001_0000;
  int unsigned m_init  = 0;
  int unsigned m_cur   = 0;
  int unsigned m_div   = 0;
  int          m_phase = 0;
  bit          m_armed = 0;
  bit          m_irq   = 0;
  int unsigned m_vec   = 0;

  always #10 clk = ~clk;   // 50 MHz

  irq_countdown_timer i_irq_countdown_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  function automatic int unsigned m_read(input int a);
    case (a)
      0: return m_entry;
      1: return m_init;
      2: return m_cur;
      default: return m_div;
    endcase
  endfunction

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model steps on each rising edge using the stable inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_entry = 32'h0001_0000; m_init = 0; m_cur = 0; m_div = 0;
      m_phase = 0; m_armed = 0; m_irq = 0; m_vec = 0;
    end else begin
      bit w_init, w_div, w_entry, restart, tk, fire;
      int period;
      int sh;
      w_entry = reg_wr && reg_addr == 2'd0;
      w_init  = reg_wr && reg_addr == 2'd1;
      w_div   = reg_wr && reg_addr == 2'd3;
      restart = w_init || w_div;
      sh      = ((((m_div >> 3) & 1) * 4) + (m_div & 3) + 1) % 8;
      period  = 1 << sh;
      tk      = !restart && ((m_phase + 1) % period == 0);
      fire    = 0;
      if (tk) begin
        if (m_cur > 0) m_cur = m_cur - 1;
        else if (m_armed) begin
          if (m_entry[17]) begin
            if (m_init != 0) fire = 1;
            m_cur = m_init;
          end else begin
            fire = 1;
            m_armed = 0;
          end
        end
      end
      m_irq = fire && !m_entry[16];
      m_vec = m_irq ? (m_entry & 32'hFF) : 0;
      if (w_entry) m_entry = reg_wdata & 32'h0003_00FF;
      if (w_div)   m_div   = reg_wdata & 32'hB;
      if (w_init) begin m_init = reg_wdata; m_cur = reg_wdata; m_armed = 1; end
      m_phase = restart ? 0 : m_phase + 1;
    end
  end

  // compare on every falling edge (R10 pulse timing and vector, live read)
  always @(negedge clk) begin
    if (rst_n) begin
      check_eq({cur_req, "/R10"}, "irq_pulse", irq_pulse, m_irq);
      check_eq({cur_req, "/R10"}, "irq_vector", irq_vector, m_vec);
      check_eq(cur_req, "rdata", reg_rdata, m_read(reg_addr));
      if (irq_pulse) pulses++;
    end
  end

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic run(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic peek(input logic [1:0] a, input string req, input longint exp);
    @(posedge clk); #2;
    reg_addr = a;
    #1 check_eq(req, "register read", reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset values
    peek(2'd0, "R1", 32'h0001_0000);
    peek(2'd1, "R1", 0);
    peek(2'd2, "R1", 0);
    peek(2'd3, "R1", 0);
    check_eq("R1", "no request after reset", irq_pulse, 0);

    // R11 entry write masking, R2 divider masking
    cur_req = "R11";
    write_reg(2'd0, 32'hFFFF_FFFF);
    peek(2'd0, "R11", 32'h0003_00FF);
    cur_req = "R2";
    write_reg(2'd3, 32'hFFFF_FFFF);
    peek(2'd3, "R2", 32'hB);

    // R6 one-shot, divide by 1 (code 7)
    begin
      int p0;
      cur_req = "R6";
      write_reg(2'd0, 32'h0000_0041);
      p0 = pulses;
      write_reg(2'd1, 5);
      run(20);
      check_eq("R6", "one-shot pulse count", pulses - p0, 1);
      peek(2'd2, "R6", 0);
    end

    // R7 periodic, reload 3, divide by 1
    begin
      int p0;
      cur_req = "R7";
      write_reg(2'd0, 32'h0002_0077);
      write_reg(2'd1, 3);
      p0 = pulses;
      run(30);
      check_eq("R7", "periodic pulse count", pulses - p0, 7);
    end

    // R8 periodic with reload 0
    begin
      int p0;
      cur_req = "R8";
      write_reg(2'd1, 0);
      p0 = pulses;
      run(20);
      check_eq("R8", "zero reload pulse count", pulses - p0, 0);
      peek(2'd2, "R8", 0);
    end

    // R9 masked periodic keeps counting, no request
    begin
      int p0;
      cur_req = "R9";
      write_reg(2'd0, 32'h0003_0055);
      p0 = pulses;
      write_reg(2'd1, 2);
      run(20);
      check_eq("R9", "masked pulse count", pulses - p0, 0);
    end

    // R3 and R4 larger dividers
    begin
      int p0;
      cur_req = "R3";
      write_reg(2'd0, 32'h0002_0033);
      write_reg(2'd3, 32'h3);        // code 3 -> shift 4
      write_reg(2'd1, 2);
      p0 = pulses;
      run(150);
      check_eq("R3", "divide-by-16 pulse count", pulses - p0, 3);
      cur_req = "R4";
      write_reg(2'd3, 32'hA);        // code 6 -> shift 7
      write_reg(2'd1, 1);
      p0 = pulses;
      run(520);
      check_eq("R4", "divide-by-128 pulse count", pulses - p0, 2);
    end

    // R5 restart mid-count in one-shot mode, divide by 2 (code 0)
    begin
      int p0;
      cur_req = "R5";
      write_reg(2'd0, 32'h0000_0012);
      write_reg(2'd3, 32'h0);
      p0 = pulses;
      write_reg(2'd1, 10);
      run(6);
      write_reg(2'd1, 3);
      peek(2'd2, "R5", 3);
      run(12);
      check_eq("R5", "restart pulse count", pulses - p0, 1);
    end

    // R11 reads of every register while counting change nothing
    cur_req = "R11";
    write_reg(2'd0, 32'h0002_0009);
    write_reg(2'd1, 4);
    for (int k = 0; k < 24; k++) begin
      @(posedge clk); #2 reg_addr = 2'(k % 4);
    end
    run(10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule